// File: doc/BRIEF.md
# Cascade Identification Logic for Chained Interrupt Controllers

This block decides which device answers an interrupt acknowledge when several interrupt controllers are chained in a two-level tree. Each device is given a role. The master is the one whose request output reaches the processor. The slaves are the ones whose request outputs feed master request inputs. In the master role the block puts a small slave identifier on shared cascade lines. In the slave role it reads those lines and compares them with its own identifier. Whichever device wins then drives the vector onto the data bus, so only one device drives the bus at a time.

The role normally comes from a strap input. The strap is high for the master and low for every slave. In buffered mode the strap pin is turned around and becomes an enable output for an external data bus transceiver, and the role then comes from a configuration bit. Priority resolution, the acknowledged request level, the per-input slave map and the slave's own identifier are all supplied from outside as inputs.

An acknowledge sequence is marked by `ack_active` being held high for at least three clock cycles. The master latches the winning level on the first rising clock edge of the sequence. A slave samples the cascade lines on the second edge.

Top module: `cas_ident_ctrl`

## Requirements
- R1: When `buffered` is 0, the role is master if `strap_in` is 1 and slave if it is 0. In the master role `cas_oe` is 1. In the slave role `cas_oe` is 0 and `cas_out` is 0.
- R2: In the master role, if bit `win_level` of `slave_map` is set when the sequence begins, `cas_out` equals that level. This holds from the first rising edge after `ack_active` rises until `ack_active` falls.
- R3: In the master role, `cas_out` is 0 outside an acknowledge sequence, before the first edge of a sequence, and throughout a sequence whose level has no slave attached.
- R4: In the master role, `bus_drive` is 1 from the first edge of a sequence until `ack_active` falls, but only if the captured level has no slave attached. It is never 1 while a slave is being identified on the cascade lines.
- R5: In the slave role, the cascade lines are sampled on the second rising edge of the sequence. If they equal `own_id`, `bus_drive` becomes 1 after that edge and stays 1 until `ack_active` falls. It is 0 after the first edge.
- R6: In the slave role, a mismatch at the sampling edge keeps `bus_drive` at 0 for the rest of the sequence, even if `cas_in` later equals `own_id`.
- R7: Changes to `win_level` or `slave_map` after the first edge of a sequence have no effect on `cas_out` or `bus_drive` in that sequence.
- R8: When `buffered` is 1, `strap_oe` is 1 and `strap_out` equals `bus_drive`. The role then follows `buf_master` (1 = master), and `strap_in` is ignored.
- R9: When `buffered` is 0, `strap_oe` and `strap_out` are both 0.
- R10: While `rst_n` is low, `cas_out` is 0 and `bus_drive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_in | input | 1 | Role strap level, 1 = master (used when not buffered) |
| strap_out | output | 1 | Transceiver enable driven onto the strap pin in buffered mode |
| strap_oe | output | 1 | Output enable for the strap pin (1 in buffered mode) |
| buffered | input | 1 | Buffered-mode select |
| buf_master | input | 1 | Role in buffered mode, 1 = master |
| slave_map | input | 2**ID_W | One bit per master input, set when a slave is attached |
| own_id | input | ID_W | Identifier programmed into this device as a slave |
| ack_active | input | 1 | High for the whole acknowledge sequence |
| win_level | input | ID_W | Acknowledged request level from the priority resolver |
| cas_in | input | ID_W | Cascade lines as read from the shared wires |
| cas_out | output | ID_W | Cascade lines as driven in the master role |
| cas_oe | output | 1 | Output enable for the cascade lines |
| bus_drive | output | 1 | This device drives the data bus this cycle |

## Verification
The bench targets the cascaded level 0. Here the identifier on the lines is zero, and a master that decided "cascaded" from the line value would wrongly drive the bus. It also changes `win_level` in the middle of a sequence, which shows up a master that does not latch the level. On the slave side it moves `cas_in` from a mismatch to a match after the sampling edge; a slave that compares continuously would start driving late. It also checks that the slave decision appears exactly one edge after the master's identifier, which catches an off-by-one sampling point. Finally, buffered mode is run with a strap level opposite to `buf_master`, which catches a role decode that still reads the pin.

// File: rtl/cas_pkg.sv
package cas_pkg;

   typedef enum logic {
      ROLE_SLAVE  = 1'b0,
      ROLE_MASTER = 1'b1
   } cas_role_e;

   localparam int unsigned ID_W_MIN = 1;
   localparam int unsigned ID_W_MAX = 4;

endpackage

// File: rtl/cas_role_sel.sv
module cas_role_sel
   import cas_pkg::*;
(
   input  logic      strap_in,
   input  logic      buffered,
   input  logic      buf_master,
   output cas_role_e role
);

   // In buffered mode the pin is an output, so the role comes from configuration.
   always_comb begin
      if (buffered) role = buf_master ? ROLE_MASTER : ROLE_SLAVE;
      else          role = strap_in   ? ROLE_MASTER : ROLE_SLAVE;
   end

endmodule

// File: rtl/cas_master_drv.sv
module cas_master_drv #(
   parameter int unsigned ID_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ack_active,
   input  logic [ID_W-1:0]      win_level,
   input  logic [(1<<ID_W)-1:0] slave_map,
   output logic [ID_W-1:0]      cas_id,
   output logic                 self_drive
);

   logic            seq_q;
   logic            casc_q;
   logic [ID_W-1:0] lvl_q;
   logic            live;

   // Capture the winner and its slave flag once, on the first edge of the sequence.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= 1'b0;
         casc_q <= 1'b0;
         lvl_q  <= '0;
      end else begin
         seq_q <= ack_active;
         if (ack_active && !seq_q) begin
            lvl_q  <= win_level;
            casc_q <= slave_map[win_level];
         end
      end
   end

   assign live       = seq_q && ack_active;
   assign cas_id     = (live && casc_q) ? lvl_q : '0;
   assign self_drive = live && !casc_q;

   // Nothing is driven on the first cycle of a sequence.
   p_quiet_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_active) |-> (cas_id == '0) && !self_drive);

   // A captured decision does not move while the sequence lasts.
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (live && $past(live)) |-> ($stable(cas_id) && $stable(self_drive)));

   // Identifier on the lines and own bus drive never coincide with a nonzero id.
   p_one_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      self_drive |-> (cas_id == '0));

endmodule

// File: rtl/cas_slave_cmp.sv
module cas_slave_cmp #(
   parameter int unsigned ID_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ack_active,
   input  logic [ID_W-1:0] cas_in,
   input  logic [ID_W-1:0] own_id,
   output logic            id_drive
);

   logic seq_q;
   logic took_q;
   logic hit_q;

   // Sample one edge after the master has latched its identifier; decide once.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q  <= 1'b0;
         took_q <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         seq_q <= ack_active;
         if (!ack_active) begin
            took_q <= 1'b0;
            hit_q  <= 1'b0;
         end else if (seq_q && !took_q) begin
            took_q <= 1'b1;
            hit_q  <= (cas_in == own_id);
         end
      end
   end

   assign id_drive = ack_active && took_q && hit_q;

   // No decision exists one edge into the sequence.
   p_late_decide_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_active) |=> !id_drive);

   // Once taken, the decision holds until the sequence ends.
   p_decision_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_active && $past(took_q) && took_q) |-> $stable(id_drive));

endmodule

// File: rtl/cas_ident_ctrl.sv
module cas_ident_ctrl
   import cas_pkg::*;
#(
   parameter int unsigned ID_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap_in,
   output logic                 strap_out,
   output logic                 strap_oe,
   input  logic                 buffered,
   input  logic                 buf_master,
   input  logic [(1<<ID_W)-1:0] slave_map,
   input  logic [ID_W-1:0]      own_id,
   input  logic                 ack_active,
   input  logic [ID_W-1:0]      win_level,
   input  logic [ID_W-1:0]      cas_in,
   output logic [ID_W-1:0]      cas_out,
   output logic                 cas_oe,
   output logic                 bus_drive
);

   localparam int unsigned N_IN = 1 << ID_W;

   generate
      if (ID_W < ID_W_MIN || ID_W > ID_W_MAX) begin : g_bad_width
         $error("cas_ident_ctrl: ID_W out of supported range");
      end
      if (N_IN != (1 << ID_W)) begin : g_bad_count
         $error("cas_ident_ctrl: input count mismatch");
      end
   endgenerate

   cas_role_e       role;
   logic [ID_W-1:0] m_cas;
   logic            m_drive;
   logic            s_drive;
   logic            is_master;

   cas_role_sel u_role (
      .strap_in   (strap_in),
      .buffered   (buffered),
      .buf_master (buf_master),
      .role       (role)
   );

   cas_master_drv #(.ID_W(ID_W)) u_master (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_active (ack_active),
      .win_level  (win_level),
      .slave_map  (slave_map),
      .cas_id     (m_cas),
      .self_drive (m_drive)
   );

   cas_slave_cmp #(.ID_W(ID_W)) u_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_active (ack_active),
      .cas_in     (cas_in),
      .own_id     (own_id),
      .id_drive   (s_drive)
   );

   assign is_master = (role == ROLE_MASTER);
   assign cas_oe    = is_master;
   assign cas_out   = is_master ? m_cas : '0;
   assign bus_drive = is_master ? m_drive : s_drive;
   assign strap_oe  = buffered;
   assign strap_out = buffered && bus_drive;

   // A slave never drives the shared lines.
   p_slave_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_oe |-> (cas_out == '0));

   // The master never drives the bus while it is naming a slave.
   p_single_driver_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_oe && cas_out != '0) |-> !bus_drive);

   // The transceiver enable follows the bus drive only in buffered mode.
   p_buf_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      strap_out |-> (strap_oe && bus_drive));

endmodule

// File: tb/cas_ident_ctrl_tb.sv
module cas_ident_ctrl_tb;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned ID_W = 3;
   localparam int unsigned NV = 10;

   // strap,buf,bmaster,map[8],own[3],lvl[3],casin[3],exp_cas[3],exp_oe,exp_drv
   localparam logic [24:0] VEC [NV] = '{
      {1'b1,1'b0,1'b0,8'h10,3'd0,3'd4,3'd0,3'd4,1'b1,1'b0},
      {1'b1,1'b0,1'b0,8'h10,3'd0,3'd2,3'd0,3'd0,1'b1,1'b1},
      {1'b1,1'b0,1'b0,8'hFF,3'd0,3'd7,3'd0,3'd7,1'b1,1'b0},
      {1'b1,1'b0,1'b0,8'h01,3'd0,3'd0,3'd0,3'd0,1'b1,1'b0},
      {1'b0,1'b0,1'b0,8'h00,3'd5,3'd0,3'd5,3'd0,1'b0,1'b1},
      {1'b0,1'b0,1'b0,8'h00,3'd5,3'd0,3'd3,3'd0,1'b0,1'b0},
      {1'b0,1'b0,1'b0,8'hFF,3'd0,3'd6,3'd0,3'd0,1'b0,1'b1},
      {1'b0,1'b1,1'b1,8'h00,3'd0,3'd3,3'd0,3'd0,1'b1,1'b1},
      {1'b1,1'b1,1'b0,8'h00,3'd2,3'd0,3'd2,3'd0,1'b0,1'b1},
      {1'b1,1'b1,1'b0,8'h00,3'd2,3'd0,3'd6,3'd0,1'b0,1'b0}
   };

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 strap_in = 1'b0;
   logic                 buffered = 1'b0;
   logic                 buf_master = 1'b0;
   logic [(1<<ID_W)-1:0] slave_map = '0;
   logic [ID_W-1:0]      own_id = '0;
   logic                 ack_active = 1'b0;
   logic [ID_W-1:0]      win_level = '0;
   logic [ID_W-1:0]      cas_in = '0;
   logic [ID_W-1:0]      cas_out;
   logic                 cas_oe;
   logic                 bus_drive;
   logic                 strap_out;
   logic                 strap_oe;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cas_ident_ctrl #(.ID_W(ID_W)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .strap_in   (strap_in),
      .strap_out  (strap_out),
      .strap_oe   (strap_oe),
      .buffered   (buffered),
      .buf_master (buf_master),
      .slave_map  (slave_map),
      .own_id     (own_id),
      .ack_active (ack_active),
      .win_level  (win_level),
      .cas_in     (cas_in),
      .cas_out    (cas_out),
      .cas_oe     (cas_oe),
      .bus_drive  (bus_drive)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [24:0] v;
      strap_in  = 1'b1;
      slave_map = 8'hFF;
      win_level = 3'd5;
      ack_active = 1'b1;
      repeat (3) @(negedge clk);
      // R10: outputs quiet in reset even with an acknowledge pending
      check("R10", "cas_out in reset", int'(cas_out), 0);
      check("R10", "bus_drive in reset", int'(bus_drive), 0);
      ack_active = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         v = VEC[i];
         strap_in   = v[24];
         buffered   = v[23];
         buf_master = v[22];
         slave_map  = v[21:14];
         own_id     = v[13:11];
         win_level  = v[10:8];
         cas_in     = v[7:5];
         @(negedge clk);
         ack_active = 1'b1;
         repeat (3) @(negedge clk);
         // R1 R2 R3 R4 R5 R6 R8 per vector
         check("R2", $sformatf("vec%0d cas_out", i), int'(cas_out), int'(v[4:2]));
         check("R1", $sformatf("vec%0d cas_oe", i), int'(cas_oe), int'(v[1]));
         check("R4", $sformatf("vec%0d bus_drive", i), int'(bus_drive), int'(v[0]));
         check("R8", $sformatf("vec%0d strap_oe", i), int'(strap_oe), int'(v[23]));
         check("R9", $sformatf("vec%0d strap_out", i), int'(strap_out), int'(v[23] & v[0]));
         ack_active = 1'b0;
         #1;
         // R3: lines and drive drop once the sequence ends
         check("R3", $sformatf("vec%0d cas_out idle", i), int'(cas_out), 0);
         check("R4", $sformatf("vec%0d drive idle", i), int'(bus_drive), 0);
         repeat (2) @(negedge clk);
      end

      // R7: master level latched; later win_level change ignored
      buffered = 1'b0; strap_in = 1'b1; slave_map = 8'h08; win_level = 3'd3;
      @(negedge clk);
      ack_active = 1'b1;
      #1;
      check("R3", "cas_out before first edge", int'(cas_out), 0);
      @(negedge clk);
      check("R2", "cas_out after first edge", int'(cas_out), 3);
      win_level = 3'd5;
      slave_map = 8'h00;
      repeat (2) @(negedge clk);
      check("R7", "cas_out after level change", int'(cas_out), 3);
      check("R7", "bus_drive after level change", int'(bus_drive), 0);
      ack_active = 1'b0;
      repeat (2) @(negedge clk);

      // R5: slave decision one edge after master id
      strap_in = 1'b0; own_id = 3'd4; cas_in = 3'd4;
      @(negedge clk);
      ack_active = 1'b1;
      @(negedge clk);
      check("R5", "slave drive after first edge", int'(bus_drive), 0);
      @(negedge clk);
      check("R5", "slave drive after second edge", int'(bus_drive), 1);
      ack_active = 1'b0;
      repeat (2) @(negedge clk);

      // R6: late match after a mismatch has no effect
      own_id = 3'd1; cas_in = 3'd2;
      @(negedge clk);
      ack_active = 1'b1;
      repeat (2) @(negedge clk);
      cas_in = 3'd1;
      repeat (2) @(negedge clk);
      check("R6", "slave drive after late match", int'(bus_drive), 0);
      ack_active = 1'b0;
      repeat (2) @(negedge clk);

      // R8: buffered master ignores a low strap
      buffered = 1'b1; buf_master = 1'b1; strap_in = 1'b0; slave_map = 8'h40; win_level = 3'd6;
      @(negedge clk);
      ack_active = 1'b1;
      repeat (3) @(negedge clk);
      check("R8", "buffered master cas_out", int'(cas_out), 6);
      check("R8", "buffered master strap_out", int'(strap_out), 0);
      ack_active = 1'b0;
      repeat (2) @(negedge clk);

      done = 1'b1;
      finish_run();
   end

endmodule